// File: doc/BRIEF.md
# Power-of-Two Triangular Smoothing Filter

This block smooths a stream of signed sensor samples with a triangular (Bartlett) window whose length is picked in powers of two. It is built from two running-average stages in series. Each stage averages its last N = 2^M inputs, and the second stage averages the first stage's outputs. The overall impulse response is therefore a triangle of 2N-1 taps, and the magnitude response is a squared sinc. Both averages divide by N with an arithmetic right shift, so no multiplier or divider is needed.

A 3-bit length field selects the exponent M. Any value above the largest supported exponent is treated as that largest value. The field is sampled every cycle. When the effective exponent changes, both stages flush to zero so that no average ever mixes two lengths. Samples arrive with a valid strobe, at whatever internal sample rate the surrounding sensor path runs. Each accepted sample produces exactly one filtered result a fixed two clock edges later.

Top module: `bartlett_smoother`

## Requirements
- R1: While reset is asserted, and until the first result after reset, `flt_vld` is 0 and `flt_data` is 0.
- R2: A sample taken with `smp_vld`=1 at a clock edge produces `flt_vld`=1 for exactly one cycle after the second following edge, provided no flush occurs in between. `flt_vld` is never 1 at any other time.
- R3: With effective exponent 0, each result equals its input sample exactly.
- R4: With effective exponent M and N = 2^M, stage one outputs y1 = floor(sum of the last N inputs / N). The result is floor(sum of the last N values of y1 / N). History that is older than the last flush or reset counts as zero.
- R5: A constant input c, applied from a flushed state, gives exactly c at the (2N-1)th result.
- R6: A change of the effective exponent flushes all history and running sums. A sample presented in that same cycle is dropped. A result still in flight (due one edge after the flush) is suppressed.
- R7: Length field values above 6 are treated as 6. A change between 6 and 7 causes no flush.
- R8: Division rounds toward minus infinity for negative values. For example, with M=1, inputs 30 then -8 give stage-one value floor(22/2)=11, and inputs -8 then -3 give floor(-11/2)=-6.
- R9: A sustained full-scale input (+32767 or -32768 for 16-bit data) at M=6 settles to exactly that value, with no overflow along the way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the release is synchronised inside the block |
| len_exp | input | 3 | Window exponent M; values above 6 are clamped to 6 |
| smp_vld | input | 1 | Input sample strobe |
| smp_data | input | DATA_W | Signed input sample |
| flt_vld | output | 1 | Filtered result strobe |
| flt_data | output | DATA_W | Signed filtered result |

## Verification
The bench builds the block with its defaults: 16-bit data and a maximum exponent of 6. That size puts the longest window, 64 taps per stage, within reach, along with the full-scale +32767 and -32768 limits where the 6 guard bits matter. A short window (M=1) is checked against hand-worked values that include negative rounding. M=0 is checked for exact pass-through. Length changes with a sample presented in the flush cycle, gaps in the strobe, and the 6-to-7 clamp are run against a reference model that sums the window directly.

// File: rtl/bw_pkg.sv
package bw_pkg;

  localparam int unsigned LEN_W = 3;

  // Effective exponent: raw request limited to the supported maximum
  function automatic logic [LEN_W-1:0] clamp_exp(input logic [LEN_W-1:0] raw,
                                                 input logic [LEN_W-1:0] lim);
    return (raw > lim) ? lim : raw;
  endfunction

endpackage

// File: rtl/bw_len_ctrl.sv
module bw_len_ctrl
  import bw_pkg::*;
#(
  parameter int unsigned MAX_EXP = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len_raw,
  output logic [LEN_W-1:0] eff_exp,
  output logic             flush
);

  logic [LEN_W-1:0] exp_nxt;

  always_comb begin
    exp_nxt = clamp_exp(len_raw, LEN_W'(MAX_EXP));
    flush   = (exp_nxt != eff_exp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eff_exp <= '0;
    else        eff_exp <= exp_nxt;
  end

endmodule

// File: rtl/bw_boxcar_stage.sv
module bw_boxcar_stage
  import bw_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned MAX_EXP = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [LEN_W-1:0]         exp_sel,
  input  logic                     in_vld,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_vld,
  output logic signed [DATA_W-1:0] out_data
);

  localparam int unsigned DEPTH = 1 << MAX_EXP;
  localparam int unsigned PTR_W = MAX_EXP;
  localparam int unsigned CNT_W = MAX_EXP + 1;
  localparam int unsigned ACC_W = DATA_W + MAX_EXP;

  logic signed [DATA_W-1:0] hist_q [DEPTH];
  logic [PTR_W-1:0]         wr_ptr_q, wr_ptr_nxt, rd_ptr;
  logic [CNT_W-1:0]         taps;
  logic signed [ACC_W-1:0]  acc_q, acc_nxt, acc_sum;
  logic signed [ACC_W-1:0]  mean;
  logic signed [DATA_W-1:0] oldest, dat_nxt;
  logic                     vld_nxt;

  // Next-state: running sum gains the new sample and loses the one N back
  always_comb begin
    taps       = CNT_W'(1) << exp_sel;
    rd_ptr     = wr_ptr_q - taps[PTR_W-1:0];
    oldest     = hist_q[rd_ptr];
    acc_sum    = acc_q + ACC_W'(in_data) - ACC_W'(oldest);
    mean       = acc_sum >>> exp_sel;
    acc_nxt    = acc_q;
    wr_ptr_nxt = wr_ptr_q;
    dat_nxt    = out_data;
    vld_nxt    = 1'b0;
    if (flush) begin
      acc_nxt    = '0;
      wr_ptr_nxt = '0;
      dat_nxt    = '0;
    end else if (in_vld) begin
      acc_nxt    = acc_sum;
      wr_ptr_nxt = wr_ptr_q + 1'b1;
      dat_nxt    = mean[DATA_W-1:0];
      vld_nxt    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      wr_ptr_q <= '0;
      out_data <= '0;
      out_vld  <= 1'b0;
    end else begin
      acc_q    <= acc_nxt;
      wr_ptr_q <= wr_ptr_nxt;
      out_data <= dat_nxt;
      out_vld  <= vld_nxt;
    end
  end

  // Delay line: cleared on flush, written with clock enable on each sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (flush) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (in_vld) begin
      hist_q[wr_ptr_q] <= in_data;
    end
  end

endmodule

// File: rtl/bartlett_smoother.sv
module bartlett_smoother
  import bw_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned MAX_EXP = 6,
  parameter int unsigned STAGES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               len_exp,
  input  logic                     smp_vld,
  input  logic signed [DATA_W-1:0] smp_data,
  output logic                     flt_vld,
  output logic signed [DATA_W-1:0] flt_data
);

  logic             rst_meta_n, rst_sync_n;
  logic [LEN_W-1:0] eff_exp;
  logic             flush;

  logic                     chain_vld [STAGES+1];
  logic signed [DATA_W-1:0] chain_dat [STAGES+1];

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  bw_len_ctrl #(.MAX_EXP(MAX_EXP)) u_len (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .len_raw (len_exp),
    .eff_exp (eff_exp),
    .flush   (flush)
  );

  assign chain_vld[0] = smp_vld;
  assign chain_dat[0] = smp_data;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    bw_boxcar_stage #(.DATA_W(DATA_W), .MAX_EXP(MAX_EXP)) u_box (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .flush    (flush),
      .exp_sel  (eff_exp),
      .in_vld   (chain_vld[s]),
      .in_data  (chain_dat[s]),
      .out_vld  (chain_vld[s+1]),
      .out_data (chain_dat[s+1])
    );
  end

  assign flt_vld  = chain_vld[STAGES];
  assign flt_data = chain_dat[STAGES];

endmodule

// File: rtl/bartlett_smoother_chk.sv
module bartlett_smoother_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned MAX_EXP = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rst_sync_n,
  input logic [2:0]               eff_exp,
  input logic                     flush,
  input logic                     smp_vld,
  input logic signed [DATA_W-1:0] smp_data,
  input logic                     flt_vld,
  input logic signed [DATA_W-1:0] flt_data
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!flt_vld && flt_data == '0));

  assert_result_due_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(smp_vld && !flush) && !flush) |=> flt_vld);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flt_vld |-> ($past(smp_vld && !flush, 2) && !$past(flush)));

  assert_bypass_exact_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flt_vld && $past(eff_exp, 2) == 3'd0) |-> flt_data == $past(smp_data, 2));

  assert_flush_kills_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |=> !flt_vld);

  assert_exp_clamped_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eff_exp <= 3'(MAX_EXP));

endmodule

bind bartlett_smoother bartlett_smoother_chk #(.DATA_W(DATA_W), .MAX_EXP(MAX_EXP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .eff_exp    (eff_exp),
  .flush      (flush),
  .smp_vld    (smp_vld),
  .smp_data   (smp_data),
  .flt_vld    (flt_vld),
  .flt_data   (flt_data)
);

// File: tb/bartlett_smoother_bench.sv
`timescale 1ns/1ps
module bartlett_smoother_bench;

  localparam int DW = 16;
  localparam int MAXE = 6;

  logic clk, rst_n, smp_vld, flt_vld;
  logic [2:0] len_exp;
  logic signed [DW-1:0] smp_data, flt_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // M=1 vectors: {input, expected result}, worked by hand from R4/R8
  localparam int TBL_N = 10;
  localparam int TBL [TBL_N][2] = '{
    '{10, 2}, '{20, 10}, '{30, 20}, '{30, 27}, '{-8, 20},
    '{-8, 1}, '{-8, -8}, '{-8, -8}, '{-3, -7}, '{-3, -5}};

  bartlett_smoother u_bartlett_smoother (
    .clk(clk), .rst_n(rst_n), .len_exp(len_exp), .smp_vld(smp_vld),
    .smp_data(smp_data), .flt_vld(flt_vld), .flt_data(flt_data));

  initial clk = 0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference model: direct window sums
  longint xh [64];
  longint yh [64];
  int cur_eff = 0;
  int q_val [$];
  int q_cyc [$];
  string q_tag [$];

  function automatic void model_clear();
    for (int i = 0; i < 64; i++) begin xh[i] = 0; yh[i] = 0; end
  endfunction

  function automatic int model_push(int d);
    longint s1, s2;
    int n;
    n = 1 << cur_eff;
    for (int i = 63; i > 0; i--) xh[i] = xh[i-1];
    xh[0] = d;
    s1 = 0;
    for (int i = 0; i < n; i++) s1 += xh[i];
    for (int i = 63; i > 0; i--) yh[i] = yh[i-1];
    yh[0] = s1 >>> cur_eff;
    s2 = 0;
    for (int i = 0; i < n; i++) s2 += yh[i];
    return int'(s2 >>> cur_eff);
  endfunction

  task automatic check(string tag, int act, int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  // Drive one cycle; use_tbl gives the expected value instead of the model
  task automatic drive(int len, bit vld, int d, string tag, bit use_tbl = 0, int tbl_exp = 0);
    int ne, e;
    @(negedge clk);
    len_exp = 3'(len); smp_vld = vld; smp_data = DW'(d);
    ne = (len > MAXE) ? MAXE : len;
    if (ne != cur_eff) begin
      while (q_cyc.size() > 0 && q_cyc[$] > cyc) begin
        void'(q_val.pop_back()); void'(q_cyc.pop_back()); void'(q_tag.pop_back());
      end
      cur_eff = ne;
      model_clear();
    end else if (vld) begin
      e = model_push(d);
      q_val.push_back(use_tbl ? tbl_exp : e);
      q_cyc.push_back(cyc + 2);
      q_tag.push_back(tag);
    end
  endtask

  // Monitor: every result must be due and correct (R2, values per tag)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
        check({q_tag[0], " missing result R2"}, 0, 1);
        void'(q_val.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
      end
      if (flt_vld) begin
        if (q_cyc.size() == 0 || q_cyc[0] != cyc) begin
          check("unexpected flt_vld R2", 1, 0);
        end else begin
          check(q_tag[0], int'(flt_data), q_val[0]);
          void'(q_val.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
        end
      end
    end
  end

  initial begin
    rst_n = 0; len_exp = 0; smp_vld = 0; smp_data = 0;
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 reset flt_vld", int'(flt_vld), 0);
    check("R1 reset flt_data", int'(flt_data), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 post-reset flt_vld", int'(flt_vld), 0);
    check("R1 post-reset flt_data", int'(flt_data), 0);

    // Table walk at M=1, back to back (R2 R4 R8)
    drive(1, 0, 0, "flush");
    for (int i = 0; i < TBL_N; i++) drive(1, 1, TBL[i][0], "R4 R8 table", 1, TBL[i][1]);
    drive(1, 0, 0, "idle");
    drive(1, 0, 0, "idle");

    // Bypass, with gaps in the strobe (R3 R2)
    drive(0, 0, 0, "flush");
    for (int i = 0; i < 8; i++) begin
      drive(0, 1, (i * 7919) % 65536 - 32768, "R3 bypass", 1, (i * 7919) % 65536 - 32768);
      if (i % 3 == 0) drive(0, 0, 0, "gap");
    end
    drive(0, 0, 0, "idle");
    drive(0, 0, 0, "idle");

    // Step response at M=6 (R5)
    drive(6, 0, 0, "flush");
    for (int i = 0; i < 127; i++) drive(6, 1, 1000, "R5 step");
    drive(6, 0, 0, "idle");
    drive(6, 0, 0, "idle");
    drive(6, 0, 0, "idle");
    check("R5 step settles at 2N-1", int'(flt_data), 1000);

    // Full scale both ways (R9)
    for (int i = 0; i < 127; i++) drive(6, 1, 32767, "R9 max");
    drive(6, 0, 0, "idle"); drive(6, 0, 0, "idle"); drive(6, 0, 0, "idle");
    check("R9 positive full scale", int'(flt_data), 32767);
    for (int i = 0; i < 127; i++) drive(6, 1, -32768, "R9 min");
    drive(6, 0, 0, "idle"); drive(6, 0, 0, "idle"); drive(6, 0, 0, "idle");
    check("R9 negative full scale", int'(flt_data), -32768);

    // Clamp: 6 -> 7 keeps history (R7)
    drive(6, 1, 500, "R7 before");
    drive(7, 1, 500, "R7 after clamp");
    drive(7, 1, -200, "R7 after clamp");
    drive(7, 0, 0, "idle"); drive(7, 0, 0, "idle");
    check("R7 no flush on 6->7 (history still negative)", int'(flt_data < 0), 1);

    // Flush with sample in same cycle and one in flight (R6)
    drive(2, 1, 40, "R6 first after flush");
    drive(2, 1, 40, "R6 first after flush");
    drive(3, 1, 77, "R6 in flight");
    drive(2, 1, 999, "R6 dropped");
    drive(2, 1, 40, "R6 fresh history");
    drive(2, 0, 0, "idle");
    drive(2, 0, 0, "idle");
    check("R6 fresh result floor(10/4)", int'(flt_data), 2);
    drive(2, 0, 0, "idle");
    check("R6 queue drained", q_cyc.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule